// File: doc/BRIEF.md
# Programmed-I/O Command and Data Queue Front-End

This block connects a 32-bit register file, driven by software, to the logic that runs the bus. Software talks to it only through port registers: it writes command descriptors and transmit words, and it reads receive words and response descriptors. No path in this block reaches memory directly. Command descriptors are 64 bits and span two DWORDs. The block builds each one from two writes in a row to a single 32-bit command port, then stores it as one entry in a 64-bit queue. Transmit, receive and response queues are each 32 bits wide. Each command and response descriptor refers to its target by an index into the device address table. That field is carried unchanged and never decoded here.

Queued commands and transmit words go to the controller over valid/ready streams. Receive words and completion responses come back from the controller over valid/ready streams. Back-pressure rules apply on every stream. An outgoing stream (`cmd_*`, `tx_*`) holds valid and data steady until ready is seen high at a clock edge. An incoming stream (`rx_*`, `resp_*`) accepts a word only on an edge where ready is high. Ready is low while that queue is full or while `soft_rst` is high. Plain status pins report empty, full and threshold flags for each queue, plus sticky overflow and underflow bits. A software reset input empties every queue and clears the sticky bits.

Top module: `pio_queue_frontend`

## Requirements
- R1: After `rst_n` is released, all four queues are empty (`q_empty`=4'hF, `q_full`=0), `cmd_valid`, `tx_valid`, `ovf` and `unf` are 0, `csr_rdata` is 0, and `rx_ready`/`resp_ready` are 1. Flag vectors use bit 0 for command, bit 1 for transmit, bit 2 for receive and bit 3 for response.
- R2: The first `csr_cmd_wr` after the last completed pair (or after reset) stores its DWORD and pushes nothing. The second pushes one 64-bit entry with the first DWORD in bits [31:0] and the second in bits [63:32]. The entry is visible on `cmd_data` with `cmd_valid` high one cycle after the second write.
- R3: If the command queue is full when the second DWORD is written, the whole descriptor is dropped. `ovf[0]` is then set and stays set. The half-assembled state is cleared, so the next write starts a new descriptor.
- R4: `csr_tx_wr` pushes `csr_wdata` onto the transmit queue. The queue drains in order through `tx_data`/`tx_valid`. A write to a full transmit queue is dropped and sets the sticky bit `ovf[1]`.
- R5: The controller pushes receive words through `rx_valid`/`rx_ready`, and `rx_ready` is low when the receive queue is full. A `csr_rx_rd` on a non-empty queue pops the oldest word and puts it on `csr_rdata` one cycle later.
- R6: The controller pushes responses through `resp_valid`/`resp_ready` under the same rules. A `csr_resp_rd` pops the oldest response onto `csr_rdata` one cycle later. If `csr_rx_rd` is high in the same cycle, `csr_resp_rd` is ignored.
- R7: A read of an empty receive or response queue leaves the queue unchanged. `csr_rdata` becomes 0, and the sticky bit `unf[0]` (receive) or `unf[1]` (response) is set.
- R8: `q_full[i]` is high exactly when queue i holds `DEPTH` entries. `q_empty[i]` is high exactly when it holds none.
- R9: For receive and response, `thr_hit` is high when the fill level is at least that queue's threshold. For command and transmit, `thr_hit` is high when the number of free slots is at least that queue's threshold.
- R10: While `soft_rst` is high, all software and controller pushes and pops are ignored. On the next edge, every queue is empty, the half-assembled command is discarded, and `ovf`/`unf` return to 0.
- R11: While an outgoing stream shows valid with ready low, valid stays high and data stays stable. Entries leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Flush all queues and clear sticky status |
| csr_cmd_wr | input | 1 | Write strobe for the command port |
| csr_tx_wr | input | 1 | Write strobe for the transmit port |
| csr_wdata | input | DW (32) | Write data for the command and transmit ports |
| csr_rx_rd | input | 1 | Read strobe for the receive port |
| csr_resp_rd | input | 1 | Read strobe for the response port |
| csr_rdata | output | DW (32) | Registered read data |
| cmd_thr | input | LVL_W (3) | Command free-space threshold |
| tx_thr | input | LVL_W (3) | Transmit free-space threshold |
| rx_thr | input | LVL_W (3) | Receive fill threshold |
| resp_thr | input | LVL_W (3) | Response fill threshold |
| q_empty | output | 4 | Empty flags {resp, rx, tx, cmd} |
| q_full | output | 4 | Full flags {resp, rx, tx, cmd} |
| thr_hit | output | 4 | Threshold flags {resp, rx, tx, cmd} |
| ovf | output | 2 | Sticky overflow {tx, cmd} |
| unf | output | 2 | Sticky underflow {resp, rx} |
| cmd_valid | output | 1 | Command entry available |
| cmd_ready | input | 1 | Controller takes the command |
| cmd_data | output | 2*DW (64) | Command descriptor |
| tx_valid | output | 1 | Transmit word available |
| tx_ready | input | 1 | Controller takes the transmit word |
| tx_data | output | DW (32) | Transmit word |
| rx_valid | input | 1 | Controller offers a receive word |
| rx_ready | output | 1 | Receive queue accepts |
| rx_data | input | DW (32) | Receive word |
| resp_valid | input | 1 | Controller offers a response |
| resp_ready | output | 1 | Response queue accepts |
| resp_data | input | DW (32) | Response descriptor |

## Verification
The bench targets how the two command DWORDs pair up. A design that swaps the halves, or keeps the stale low half after a dropped descriptor, puts wrong data on `cmd_data` when that queue is next drained. It fills every queue up to and past its limit. A design that lets a write overwrite a full queue, or forgets the sticky overflow, shows extra or corrupted entries when drained, or `ovf` reads zero. It reads empty queues. A design that pops anyway, or returns stale data, shows nonzero `csr_rdata` or a lost word later. It also checks that a soft reset between the two halves of a command discards the first half, and that the threshold flags switch at the exact level for each direction.

// File: rtl/pio_q_pkg.sv
package pio_q_pkg;
  localparam int Q_CMD  = 0;
  localparam int Q_TX   = 1;
  localparam int Q_RX   = 2;
  localparam int Q_RESP = 3;
  localparam int NUM_Q  = 4;
endpackage

// File: rtl/pio_q_fifo.sv
module pio_q_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  assign empty = (level == '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign dout  = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      level <= level + 1'b1;
      else if (pop && !push) level <= level - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> !full || pop);
  p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush |-> !empty);
  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
endmodule

// File: rtl/pio_cmd_packer.sv
module pio_cmd_packer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          q_full,
  output logic          push,
  output logic [2*DW-1:0] push_data,
  output logic          drop
);
  logic          half;
  logic [DW-1:0] low_q;

  assign push      = wr && half && !flush && !q_full;
  assign drop      = wr && half && !flush && q_full;
  assign push_data = {wdata, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b0;
      low_q <= '0;
    end else if (flush) begin
      half  <= 1'b0;
    end else if (wr) begin
      if (!half) low_q <= wdata;
      half <= !half;
    end
  end

  p_pair_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr && !flush && !half |=> half);
  p_drop_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !half);
endmodule

// File: rtl/pio_queue_frontend.sv
module pio_queue_frontend
  import pio_q_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              csr_cmd_wr,
  input  logic              csr_tx_wr,
  input  logic [DW-1:0]     csr_wdata,
  input  logic              csr_rx_rd,
  input  logic              csr_resp_rd,
  output logic [DW-1:0]     csr_rdata,
  input  logic [LVL_W-1:0]  cmd_thr,
  input  logic [LVL_W-1:0]  tx_thr,
  input  logic [LVL_W-1:0]  rx_thr,
  input  logic [LVL_W-1:0]  resp_thr,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_full,
  output logic [NUM_Q-1:0]  thr_hit,
  output logic [1:0]        ovf,
  output logic [1:0]        unf,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2*DW-1:0]   cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [DW-1:0]     resp_data
);
  logic [LVL_W-1:0] lvl [NUM_Q];
  logic [DW-1:0]    rx_head, resp_head;

  logic cmd_push, cmd_drop;
  logic [2*DW-1:0] cmd_push_data;
  logic tx_push, tx_drop, rx_push, resp_push;
  logic cmd_pop, tx_pop, rx_pop, resp_pop;
  logic rx_rd_eff, resp_rd_eff;

  pio_cmd_packer #(.DW(DW)) u_packer (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .wr(csr_cmd_wr), .wdata(csr_wdata), .q_full(q_full[Q_CMD]),
    .push(cmd_push), .push_data(cmd_push_data), .drop(cmd_drop)
  );

  assign tx_push   = csr_tx_wr && !soft_rst && !q_full[Q_TX];
  assign tx_drop   = csr_tx_wr && !soft_rst &&  q_full[Q_TX];
  assign rx_ready  = !q_full[Q_RX]   && !soft_rst;
  assign resp_ready= !q_full[Q_RESP] && !soft_rst;
  assign rx_push   = rx_valid   && rx_ready;
  assign resp_push = resp_valid && resp_ready;

  assign cmd_valid = !q_empty[Q_CMD];
  assign tx_valid  = !q_empty[Q_TX];
  assign cmd_pop   = cmd_valid && cmd_ready && !soft_rst;
  assign tx_pop    = tx_valid  && tx_ready  && !soft_rst;

  assign rx_rd_eff   = csr_rx_rd && !soft_rst;
  assign resp_rd_eff = csr_resp_rd && !csr_rx_rd && !soft_rst;
  assign rx_pop      = rx_rd_eff   && !q_empty[Q_RX];
  assign resp_pop    = resp_rd_eff && !q_empty[Q_RESP];

  pio_q_fifo #(.W(2*DW), .DEPTH(DEPTH)) u_cmd_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(cmd_push), .din(cmd_push_data), .pop(cmd_pop), .dout(cmd_data),
    .level(lvl[Q_CMD]), .empty(q_empty[Q_CMD]), .full(q_full[Q_CMD])
  );
  pio_q_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(tx_push), .din(csr_wdata), .pop(tx_pop), .dout(tx_data),
    .level(lvl[Q_TX]), .empty(q_empty[Q_TX]), .full(q_full[Q_TX])
  );
  pio_q_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(rx_push), .din(rx_data), .pop(rx_pop), .dout(rx_head),
    .level(lvl[Q_RX]), .empty(q_empty[Q_RX]), .full(q_full[Q_RX])
  );
  pio_q_fifo #(.W(DW), .DEPTH(DEPTH)) u_resp_q (
    .clk(clk), .rst_n(rst_n), .flush(soft_rst),
    .push(resp_push), .din(resp_data), .pop(resp_pop), .dout(resp_head),
    .level(lvl[Q_RESP]), .empty(q_empty[Q_RESP]), .full(q_full[Q_RESP])
  );

  // Outbound queues flag free space, inbound queues flag fill level.
  assign thr_hit[Q_CMD]  = (LVL_W'(DEPTH) - lvl[Q_CMD]) >= cmd_thr;
  assign thr_hit[Q_TX]   = (LVL_W'(DEPTH) - lvl[Q_TX])  >= tx_thr;
  assign thr_hit[Q_RX]   = lvl[Q_RX]   >= rx_thr;
  assign thr_hit[Q_RESP] = lvl[Q_RESP] >= resp_thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf       <= '0;
      unf       <= '0;
      csr_rdata <= '0;
    end else if (soft_rst) begin
      ovf <= '0;
      unf <= '0;
    end else begin
      if (cmd_drop) ovf[0] <= 1'b1;
      if (tx_drop)  ovf[1] <= 1'b1;
      if (rx_rd_eff) begin
        csr_rdata <= q_empty[Q_RX] ? '0 : rx_head;
        if (q_empty[Q_RX]) unf[0] <= 1'b1;
      end else if (resp_rd_eff) begin
        csr_rdata <= q_empty[Q_RESP] ? '0 : resp_head;
        if (q_empty[Q_RESP]) unf[1] <= 1'b1;
      end
    end
  end

  p_cmd_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[0] && !soft_rst |=> ovf[0]);
  p_tx_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf[1] && !soft_rst |=> ovf[1]);
  p_empty_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rx_rd && q_empty[Q_RX] && !soft_rst |=> csr_rdata == '0 && unf[0]);
  p_empty_read_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rx_rd && q_empty[Q_RX] && !rx_valid && !soft_rst |=> q_empty[Q_RX]);
  p_rx_ready_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full[Q_RX] |-> !rx_ready);
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> q_empty == '1 && ovf == '0 && unf == '0);
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !soft_rst |=> cmd_valid && $stable(cmd_data));
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !soft_rst |=> tx_valid && $stable(tx_data));
endmodule

// File: tb/pio_queue_frontend_tb.sv
`timescale 1ns/1ps
module pio_queue_frontend_tb;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic csr_cmd_wr = 1'b0, csr_tx_wr = 1'b0, csr_rx_rd = 1'b0, csr_resp_rd = 1'b0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic [LVL_W-1:0] cmd_thr = '0, tx_thr = '0, rx_thr = '0, resp_thr = '0;
  logic [3:0] q_empty, q_full, thr_hit;
  logic [1:0] ovf, unf;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [2*DW-1:0] cmd_data;
  logic tx_valid, tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic rx_valid = 1'b0, rx_ready;
  logic [DW-1:0] rx_data = '0;
  logic resp_valid = 1'b0, resp_ready;
  logic [DW-1:0] resp_data = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pio_queue_frontend #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .csr_cmd_wr(csr_cmd_wr), .csr_tx_wr(csr_tx_wr), .csr_wdata(csr_wdata),
    .csr_rx_rd(csr_rx_rd), .csr_resp_rd(csr_resp_rd), .csr_rdata(csr_rdata),
    .cmd_thr(cmd_thr), .tx_thr(tx_thr), .rx_thr(rx_thr), .resp_thr(resp_thr),
    .q_empty(q_empty), .q_full(q_full), .thr_hit(thr_hit), .ovf(ovf), .unf(unf),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Each helper drives for one cycle, then returns at the next falling edge.
  task automatic cmd_wr(input logic [31:0] d);
    csr_cmd_wr = 1'b1; csr_wdata = d;
    @(negedge clk); csr_cmd_wr = 1'b0;
  endtask
  task automatic tx_wr(input logic [31:0] d);
    csr_tx_wr = 1'b1; csr_wdata = d;
    @(negedge clk); csr_tx_wr = 1'b0;
  endtask
  task automatic rx_push(input logic [31:0] d);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic resp_push(input logic [31:0] d);
    resp_valid = 1'b1; resp_data = d;
    @(negedge clk); resp_valid = 1'b0;
  endtask
  task automatic rx_rd();
    csr_rx_rd = 1'b1; @(negedge clk); csr_rx_rd = 1'b0;
  endtask
  task automatic resp_rd();
    csr_resp_rd = 1'b1; @(negedge clk); csr_resp_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 64'(q_empty), 64'hF);
    chk("R1 full", 64'(q_full), 64'h0);
    chk("R1 sticky", 64'({ovf, unf}), 64'h0);
    chk("R1 valid", 64'({cmd_valid, tx_valid}), 64'h0);
    chk("R1 rdata", 64'(csr_rdata), 64'h0);
    chk("R1 ready", 64'({rx_ready, resp_ready}), 64'h3);
  endtask

  task automatic t_cmd();
    cmd_thr = 3'd1;
    cmd_wr(32'hA000_0000);
    chk("R2 no push after low half", 64'(cmd_valid), 64'h0);
    cmd_wr(32'hB000_0000);
    chk("R2 valid after pair", 64'(cmd_valid), 64'h1);
    chk("R2 dword order", cmd_data, {32'hB000_0000, 32'hA000_0000});
    @(negedge clk);
    chk("R11 cmd held", {cmd_valid, cmd_data[62:0]}, {1'b1, 31'h3000_0000, 32'hA000_0000});
    chk("R9 cmd free ok", 64'(thr_hit[0]), 64'h1);
    for (int k = 1; k < DEPTH; k++) begin
      cmd_wr(32'h1000_0000 + k);
      cmd_wr(32'h2000_0000 + k);
    end
    chk("R8 cmd full", 64'(q_full[0]), 64'h1);
    chk("R9 cmd no free", 64'(thr_hit[0]), 64'h0);
    cmd_wr(32'hDEAD_0001);
    cmd_wr(32'hDEAD_0002);
    chk("R3 cmd overflow", 64'(ovf), 64'h1);
    cmd_ready = 1'b1;
    chk("R11 cmd order 0", cmd_data, {32'hB000_0000, 32'hA000_0000});
    @(negedge clk);
    for (int k = 1; k < DEPTH; k++) begin
      chk("R11 cmd order", cmd_data, {32'h2000_0000 + k, 32'h1000_0000 + k});
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    chk("R8 cmd empty after drain", 64'(q_empty[0]), 64'h1);
    cmd_wr(32'hC000_0001);
    chk("R3 fresh pair starts low", 64'(cmd_valid), 64'h0);
    cmd_wr(32'hC000_0002);
    chk("R3 new descriptor", cmd_data, {32'hC000_0002, 32'hC000_0001});
    chk("R3 ovf still set", 64'(ovf[0]), 64'h1);
    cmd_ready = 1'b1; @(negedge clk); cmd_ready = 1'b0;
  endtask

  task automatic t_tx();
    tx_thr = 3'd1;
    for (int k = 0; k <= DEPTH; k++) tx_wr(32'h5500_0000 + k);
    chk("R4 tx overflow", 64'(ovf[1]), 64'h1);
    chk("R8 tx full", 64'(q_full[1]), 64'h1);
    chk("R9 tx no free", 64'(thr_hit[1]), 64'h0);
    tx_ready = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      chk("R4 tx order", 64'({tx_valid, tx_data}), {31'h0, 1'b1, 32'h5500_0000 + k});
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R4 extra word dropped", 64'(tx_valid), 64'h0);
  endtask

  task automatic t_rx();
    rx_thr = 3'd3;
    rx_push(32'h7700_0000);
    rx_push(32'h7700_0001);
    chk("R9 rx below thr", 64'(thr_hit[2]), 64'h0);
    rx_push(32'h7700_0002);
    chk("R9 rx at thr", 64'(thr_hit[2]), 64'h1);
    rx_push(32'h7700_0003);
    chk("R5 rx_ready low when full", 64'({rx_ready, q_full[2]}), 64'h1);
    rx_push(32'hBAD0_BAD0);
    for (int k = 0; k < DEPTH; k++) begin
      rx_rd();
      chk("R5 rx read data", 64'(csr_rdata), 64'(32'h7700_0000 + k));
    end
    rx_rd();
    chk("R7 rx empty read zero", 64'(csr_rdata), 64'h0);
    chk("R7 rx underflow", 64'(unf), 64'h1);
    rx_push(32'h7700_0099);
    rx_rd();
    chk("R7 empty read did not pop", 64'(csr_rdata), 64'(32'h7700_0099));
  endtask

  task automatic t_resp();
    resp_thr = 3'd1;
    resp_rd();
    chk("R7 resp underflow", 64'({unf[1], csr_rdata}), {31'h0, 1'b1, 32'h0});
    resp_push(32'h0000_1234);
    resp_push(32'h0000_5678);
    chk("R9 resp thr", 64'(thr_hit[3]), 64'h1);
    rx_push(32'h0000_00AA);
    csr_rx_rd = 1'b1; csr_resp_rd = 1'b1;
    @(negedge clk); csr_rx_rd = 1'b0; csr_resp_rd = 1'b0;
    chk("R6 rx wins tie", 64'(csr_rdata), 64'h0000_00AA);
    resp_rd();
    chk("R6 resp oldest", 64'(csr_rdata), 64'h0000_1234);
    resp_rd();
    chk("R6 resp next", 64'(csr_rdata), 64'h0000_5678);
  endtask

  task automatic t_soft();
    tx_wr(32'h1);
    rx_push(32'h2);
    cmd_wr(32'hEEEE_0001);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk("R10 all empty", 64'(q_empty), 64'hF);
    chk("R10 sticky cleared", 64'({ovf, unf}), 64'h0);
    cmd_wr(32'hF000_0001);
    chk("R10 half discarded", 64'(cmd_valid), 64'h0);
    cmd_wr(32'hF000_0002);
    chk("R10 fresh pair", cmd_data, {32'hF000_0002, 32'hF000_0001});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_tx();
    t_rx();
    t_resp();
    t_soft();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule